// File: doc/BRIEF.md
# Prescaled Single-Channel Pulse-Width Modulator

This block generates one pulse-width modulated output from a reference clock of nominally 24 MHz. Software programs it through a small 32-bit register port: a control word picks one of eleven clock division ratios (or none), sets the output polarity, and chooses between free-running repetition and a single triggered pulse. A second word holds the period length and the active length, both counted in divided clock cycles.

A new period word is held in a shadow copy and only takes effect when the running period finishes, so the waveform never shows a shortened or merged period. A read-only pending flag in the control word tells software that a new period setting is still waiting. When the divider is bypassed, the output toggles on every reference clock edge and gives the fastest waveform the block can make.

Top module: `scaled_pwm`

## Requirements
- R1: The control word sits at byte address 0x00 and the period word at 0x04; other addresses read 0 and ignore writes. Control fields: divider code [3:0], enable [4], polarity [5], gate [6], mode [7] (0 repeat, 1 single pulse), pulse start [8], divider bypass [9], pending flag [28] (read-only). Period fields: total-minus-one [31:16], active count [15:0]. Reads return the last written value; undefined bits read 0. After reset all fields are 0 and the output is 1.
- R2: Divider codes 0..4 divide the reference clock by 120, 180, 240, 360, 480; codes 8..12 by 12000, 24000, 36000, 48000, 72000; code 15 by 1.
- R3: The waveform runs only while enable and gate are both 1; otherwise the output holds the inactive level.
- R4: Codes 5, 6, 7, 13 and 14 are reserved: with one selected the block does not count and the output holds the inactive level.
- R5: In repeat mode one period lasts (total-minus-one + 1) times the division ratio reference cycles; within each period the first (active count) divided cycles are active and the rest inactive; the output is registered, so it lags the internal count by one reference cycle.
- R6: Polarity 1 drives the active part high and the idle level low; polarity 0 drives the active part low and the idle level high.
- R7: An active count of at least total-minus-one + 1 keeps the output active for the whole period; an active count of 0 keeps it inactive.
- R8: A period write sets the pending flag in the next cycle; the new values take effect at the end of the running period (or at the next cycle when the block is not counting), and the flag clears at that moment.
- R9: In single-pulse mode, writing the control word with start 1 yields exactly one period, after which start reads 0 and the output returns to the inactive level; start written while mode is 0 reads back 0 and has no effect.
- R10: With bypass set while the waveform runs (R3, R4 met), the output inverts on every reference clock cycle and the period counter stays at rest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with its default parameters: 16-bit period fields and a 3-bit byte address, so the full register layout and every divider code are in play. Short period settings keep the small divisors (1 to 480) and the 12000 divisor within a few tens of thousands of cycles, so exact period edges are compared there, while the reserved codes and the polarity, pulse, pending-flag and bypass behaviour are exercised with the undivided clock.

// File: rtl/scaled_pwm_pkg.sv
package scaled_pwm_pkg;

    localparam int REG_W   = 32;
    localparam int CODE_W  = 4;
    localparam int DIV_W   = 17;
    localparam int BUSY_BIT = 28;

    // Control word layout, bit 9 down to bit 0.
    typedef struct packed {
        logic              bypass;
        logic              start;
        logic              mode;
        logic              gate;
        logic              level;
        logic              enable;
        logic [CODE_W-1:0] code;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Division ratio per code; 0 marks a reserved code.
    function automatic logic [DIV_W-1:0] code_to_ratio(input logic [CODE_W-1:0] c);
        logic [DIV_W-1:0] r;
        case (c)
            4'd0:    r = DIV_W'(120);
            4'd1:    r = DIV_W'(180);
            4'd2:    r = DIV_W'(240);
            4'd3:    r = DIV_W'(360);
            4'd4:    r = DIV_W'(480);
            4'd8:    r = DIV_W'(12000);
            4'd9:    r = DIV_W'(24000);
            4'd10:   r = DIV_W'(36000);
            4'd11:   r = DIV_W'(48000);
            4'd12:   r = DIV_W'(72000);
            4'd15:   r = DIV_W'(1);
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import scaled_pwm_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              boundary,
    input  logic              counting,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  total,
    output logic [CNT_W-1:0]  active,
    output logic              busy
);

    localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] PER_OFS  = ADDR_W'(4);
    localparam int TOT_LSB = REG_W / 2;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] sh_total;
        logic [CNT_W-1:0] sh_active;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] active;
        logic             busy;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic wr_ctrl, wr_per;

    assign wr_ctrl = we && (addr == CTRL_OFS);
    assign wr_per  = we && (addr == PER_OFS);

    always_comb begin
        st_d = st_q;
        if (st_q.busy && (boundary || !counting)) begin
            st_d.total  = st_q.sh_total;
            st_d.active = st_q.sh_active;
            st_d.busy   = 1'b0;
        end
        if (boundary) begin
            st_d.ctrl.start = 1'b0;
        end
        if (wr_ctrl) begin
            st_d.ctrl       = ctrl_t'(wdata[CTRL_W-1:0]);
            st_d.ctrl.start = wdata[8] & wdata[7];
        end
        if (wr_per) begin
            st_d.sh_total  = wdata[TOT_LSB +: CNT_W];
            st_d.sh_active = wdata[0 +: CNT_W];
            st_d.busy      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_OFS) begin
            rdata[CTRL_W-1:0] = st_q.ctrl;
            rdata[BUSY_BIT]   = st_q.busy;
        end else if (addr == PER_OFS) begin
            rdata[TOT_LSB +: CNT_W] = st_q.sh_total;
            rdata[0 +: CNT_W]       = st_q.sh_active;
        end
    end

    assign ctrl   = st_q.ctrl;
    assign total  = st_q.total;
    assign active = st_q.active;
    assign busy   = st_q.busy;

    // R8: a pending update survives until a boundary while counting
    assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && st_q.busy && !boundary && !wr_per) |=> st_q.busy);

    // R8: at a boundary the waiting shadow becomes the live setting
    assert_apply_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && st_q.busy) |=> (st_q.total == $past(st_q.sh_total)));

    // R9: start clears at the end of the pulse period
    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !wr_ctrl) |=> !st_q.ctrl.start);

    // R9: start never stands while repeat mode is selected
    assert_start_needs_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.start |-> st_q.ctrl.mode);

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import scaled_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             counting,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] pc;
    } psc_state_t;

    psc_state_t st_d, st_q;

    // The compare is >= so that a ratio lowered mid-count still wraps.
    assign tick = counting && (st_q.pc >= (ratio - DIV_W'(1)));

    always_comb begin
        st_d = st_q;
        if (!counting || tick) begin
            st_d.pc = '0;
        end else begin
            st_d.pc = st_q.pc + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: the divided count never passes the selected ratio
    assert_pc_below_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && $past(counting) && $stable(ratio)) |-> (st_q.pc < ratio));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             counting,
    input  logic             tick,
    input  logic             toggle_run,
    input  logic             level,
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] active,
    output logic             boundary,
    output logic             pwm_out
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic in_active;

    assign boundary  = tick && (st_q.cnt == total);
    assign in_active = st_q.cnt < active;

    always_comb begin
        st_d = st_q;
        if (!counting) begin
            st_d.cnt = '0;
        end else if (boundary) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        if (toggle_run) begin
            st_d.out = !st_q.out;
        end else if (counting) begin
            st_d.out = in_active ? level : !level;
        end else begin
            st_d.out = !level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.out <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_out = st_q.out;

    // R5: the period count stays within the programmed length
    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        counting |-> (st_q.cnt <= total));

endmodule

// File: rtl/scaled_pwm.sv
module scaled_pwm
    import scaled_pwm_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              pwm_out
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] total, active;
    logic             busy;
    logic [DIV_W-1:0] ratio;
    logic             run, toggle_run, counting, tick, boundary;

    assign ratio      = code_to_ratio(ctrl.code);
    assign run        = ctrl.enable && ctrl.gate && (ratio != '0);
    assign toggle_run = run && ctrl.bypass;
    assign counting   = run && !ctrl.bypass && (!ctrl.mode || ctrl.start);

    pwm_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .boundary (boundary),
        .counting (counting),
        .ctrl     (ctrl),
        .total    (total),
        .active   (active),
        .busy     (busy)
    );

    pwm_prescaler u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .counting (counting),
        .ratio    (ratio),
        .tick     (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .counting   (counting),
        .tick       (tick),
        .toggle_run (toggle_run),
        .level      (ctrl.level),
        .total      (total),
        .active     (active),
        .boundary   (boundary),
        .pwm_out    (pwm_out)
    );

    // R3 / R4: a stopped or reserved-code channel idles at the inactive level
    assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pwm_out == !$past(ctrl.level)));

    // R10: the bypassed output flips every cycle
    assert_bypass_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_run |=> (pwm_out != $past(pwm_out)));

    // R7: an active count covering the period keeps the output active
    assert_full_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && ({1'b0, active} >= ({1'b0, total} + (CNT_W+1)'(1))))
        |=> (pwm_out == $past(ctrl.level)));

    // R8: the pending flag is visible whenever an update waits
    assert_busy_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_addr == 3'd0) |-> reg_rdata[BUSY_BIT]);

endmodule

// File: tb/scaled_pwm_bench.sv
`timescale 1ns/100ps
module scaled_pwm_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        pwm_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    scaled_pwm u_scaled_pwm (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    // ---------------- behavioural reference ----------------
    int     m_code;
    bit     m_en, m_lvl, m_gate, m_mode, m_start, m_byp, m_busy, m_out;
    longint m_total, m_active, m_sh_total, m_sh_active, m_el;

    function automatic longint ratio_of(int c);
        if (c == 15) return 1;
        if (c >= 0 && c <= 4) begin
            longint t [5] = '{120, 180, 240, 360, 480};
            return t[c];
        end
        if (c >= 8 && c <= 12) begin
            longint u [5] = '{12000, 24000, 36000, 48000, 72000};
            return u[c-8];
        end
        return 0;
    endfunction

    function automatic logic [31:0] model_read(logic [2:0] a);
        logic [31:0] r = 32'd0;
        if (a == 3'd0) begin
            r[3:0] = 4'(m_code);
            r[4] = m_en; r[5] = m_lvl; r[6] = m_gate; r[7] = m_mode;
            r[8] = m_start; r[9] = m_byp; r[28] = m_busy;
        end else if (a == 3'd4) begin
            r[31:16] = 16'(m_sh_total);
            r[15:0]  = 16'(m_sh_active);
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 0; m_en = 0; m_lvl = 0; m_gate = 0; m_mode = 0;
            m_start = 0; m_byp = 0; m_busy = 0; m_out = 1;
            m_total = 0; m_active = 0; m_sh_total = 0; m_sh_active = 0; m_el = 0;
        end else begin
            longint div;
            bit run, trun, cnting, bnd;
            div    = ratio_of(m_code);
            run    = m_en && m_gate && (div != 0);
            trun   = run && m_byp;
            cnting = run && !m_byp && (!m_mode || m_start);
            bnd    = cnting && (m_el == (m_total + 1) * div - 1);
            if (trun)        m_out = !m_out;
            else if (cnting) m_out = ((m_el / div) < m_active) ? m_lvl : !m_lvl;
            else             m_out = !m_lvl;
            m_el = cnting ? (bnd ? 0 : m_el + 1) : 0;
            if (m_busy && (bnd || !cnting)) begin
                m_total = m_sh_total; m_active = m_sh_active; m_busy = 0;
            end
            if (bnd) m_start = 0;
            if (reg_we && reg_addr == 3'd0) begin
                m_code = int'(reg_wdata[3:0]);
                m_en = reg_wdata[4]; m_lvl = reg_wdata[5]; m_gate = reg_wdata[6];
                m_mode = reg_wdata[7]; m_start = reg_wdata[8] & reg_wdata[7];
                m_byp = reg_wdata[9];
            end
            if (reg_we && reg_addr == 3'd4) begin
                m_sh_total = longint'(reg_wdata[31:16]);
                m_sh_active = longint'(reg_wdata[15:0]);
                m_busy = 1;
            end
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // every-cycle comparison, away from the active edge
    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk(cur_req, "pwm_out", {31'd0, pwm_out}, {31'd0, m_out});
            chk(cur_req, "reg_rdata", reg_rdata, model_read(reg_addr));
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 32'd0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // control word: code | en<<4 | lvl<<5 | gate<<6 | mode<<7 | start<<8 | byp<<9
    function automatic logic [31:0] cw(int code, bit en, bit lvl, bit gate,
                                       bit mode, bit start, bit byp);
        return {22'd0, byp, start, mode, gate, lvl, en, 4'(code)};
    endfunction

    function automatic logic [31:0] pw(int tot, int act);
        return {16'(tot), 16'(act)};
    endfunction

    task automatic stop_ch();
        wr(3'd0, 32'd0);
        idle(2);
    endtask

    initial begin
        // R1: reset state
        idle(3);
        @(negedge clk);
        chk("R1", "reset out", {31'd0, pwm_out}, 32'd1);
        chk("R1", "reset ctrl", reg_rdata, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R1: readback and unused bits
        cur_req = "R1";
        wr(3'd4, 32'h1234_5678);
        idle(3);
        @(negedge clk); reg_addr = 3'd4; #1;
        chk("R1", "period readback", reg_rdata, 32'h1234_5678);
        reg_addr = 3'd2; #1;
        chk("R1", "undecoded address", reg_rdata, 32'd0);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd0, cw(3, 0, 1, 0, 0, 0, 0) | 32'hE000_FC00);
        @(negedge clk); reg_addr = 3'd0; #1;
        chk("R1", "ctrl unused bits", reg_rdata, cw(3, 0, 1, 0, 0, 0, 0));
        stop_ch();

        // R5 / R6: undivided clock, both polarities
        cur_req = "R5";
        wr(3'd4, pw(9, 3));
        idle(2);
        wr(3'd0, cw(15, 1, 1, 1, 0, 0, 0));
        idle(45);
        cur_req = "R6";
        stop_ch();
        wr(3'd0, cw(15, 1, 0, 1, 0, 0, 0));
        idle(35);
        stop_ch();

        // R2: divided clocks
        cur_req = "R2";
        wr(3'd4, pw(2, 1));
        idle(2);
        wr(3'd0, cw(0, 1, 1, 1, 0, 0, 0));
        idle(800);
        stop_ch();
        foreach (ratio_of_codes[i]) begin
            wr(3'd4, pw(1, 1));
            idle(2);
            wr(3'd0, cw(ratio_of_codes[i], 1, 1, 1, 0, 0, 0));
            idle(1100);
            stop_ch();
        end
        wr(3'd4, pw(1, 1));
        idle(2);
        wr(3'd0, cw(8, 1, 1, 1, 0, 0, 0));
        idle(25000);
        stop_ch();

        // R4: reserved codes
        cur_req = "R4";
        wr(3'd4, pw(3, 2));
        foreach (reserved_codes[i]) begin
            wr(3'd0, cw(reserved_codes[i], 1, 1, 1, 0, 0, 0));
            idle(6);
            @(negedge clk);
            chk("R4", "reserved code idles", {31'd0, pwm_out}, 32'd0);
            stop_ch();
        end

        // R3: enable without gate and gate without enable
        cur_req = "R3";
        wr(3'd0, cw(15, 1, 1, 0, 0, 0, 0));
        idle(8);
        chk("R3", "enable only", {31'd0, pwm_out}, 32'd0);
        wr(3'd0, cw(15, 0, 1, 1, 0, 0, 0));
        idle(8);
        chk("R3", "gate only", {31'd0, pwm_out}, 32'd0);
        stop_ch();

        // R7: active count covering or absent
        cur_req = "R7";
        wr(3'd4, pw(4, 5));
        idle(2);
        wr(3'd0, cw(15, 1, 1, 1, 0, 0, 0));
        idle(20);
        wr(3'd4, pw(4, 16'hFFFF));
        idle(20);
        wr(3'd4, pw(4, 0));
        idle(20);
        stop_ch();

        // R8: pending flag while running
        cur_req = "R8";
        wr(3'd4, pw(19, 10));
        idle(2);
        wr(3'd0, cw(15, 1, 1, 1, 0, 0, 0));
        idle(3);
        wr(3'd4, pw(5, 2));
        @(negedge clk); reg_addr = 3'd0; #1;
        chk("R8", "pending set after write", {31'd0, reg_rdata[28]}, 32'd1);
        idle(40);
        chk("R8", "pending cleared", {31'd0, reg_rdata[28]}, 32'd0);
        stop_ch();

        // R9: single pulse and start in repeat mode
        cur_req = "R9";
        wr(3'd4, pw(4, 2));
        idle(2);
        wr(3'd0, cw(15, 1, 1, 1, 1, 1, 0));
        idle(20);
        @(negedge clk); reg_addr = 3'd0; #1;
        chk("R9", "start self-clears", {31'd0, reg_rdata[8]}, 32'd0);
        chk("R9", "idle after pulse", {31'd0, pwm_out}, 32'd0);
        wr(3'd0, cw(15, 1, 1, 1, 1, 1, 0));
        idle(12);
        wr(3'd0, cw(15, 1, 1, 1, 0, 1, 0));
        @(negedge clk); reg_addr = 3'd0; #1;
        chk("R9", "start ignored in repeat mode", {31'd0, reg_rdata[8]}, 32'd0);
        idle(15);
        stop_ch();

        // R10: bypass
        cur_req = "R10";
        wr(3'd0, cw(15, 1, 1, 1, 0, 0, 1));
        idle(15);
        wr(3'd0, cw(0, 1, 0, 1, 0, 0, 1));
        idle(15);
        stop_ch();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    int ratio_of_codes [5] = '{1, 2, 3, 4, 15};
    int reserved_codes [5] = '{5, 6, 7, 13, 14};

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL all watchdog expired act=%0d exp=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule